// File: doc/BRIEF.md
# Temporal Leaky-Integrate-and-Fire Neuron

This block is one digital spiking neuron. Each of its synapse inputs carries a single-cycle spike bit. A spike launches a current pulse for that synapse. The pulse is a trapezoid shaped by per-synapse registers: a silent wait, a linear climb to a signed peak, a plateau, and a linear descent back to zero. A negative peak makes the synapse inhibitory, so the mix of excitatory and inhibitory inputs is set entirely by configuration.

On every clock, the currents of all synapses are added into a signed, saturating membrane accumulator. At a programmable power-of-two interval, the accumulator is first scaled by an 8-bit fraction and reloaded. This gives a stepwise exponential leak.

A comparator fires the neuron when the membrane exceeds a threshold. A shift register then masks the comparator for a fixed number of cycles. The membrane itself is never reset by a spike, so a potential that stays high makes the neuron fire again at the fastest rate the refractory window allows.

Top module: `tlif_neuron`

## Requirements
- R1: While `rst_n` is low at a clock edge, the membrane becomes 0, `fire_out` becomes 0, every synapse waveform returns to idle and the decay interval counter restarts from 0.
- R2: A spike on synapse i, sampled at an edge, gives a current of 0 for the next `td` cycles. The rise then lasts 2^rs cycles, with sample k (0-based) equal to floor(h*(k+1)/2^rs). Next comes a plateau at h for `tp` cycles, skipped when `tp`=0. The fall lasts 2^fs cycles, with sample k equal to floor(h*(2^fs-1-k)/2^fs). After the fall the current is 0. Fields are packed at bit `i*8` for delay, plateau and height, and at bit `i*3` for the rise and fall exponents.
- R3: A synapse whose 8-bit two's-complement height is negative contributes negative current and lowers the membrane.
- R4: Each cycle the membrane becomes base + (sum of all synapse currents in that cycle). The result saturates to the 24-bit signed range [-8388608, 8388607].
- R5: A decay tick happens on cycle c (counted from 0 after reset) when the low `decay_exp` bits of c are all ones. On a tick, base is floor(membrane*decay_frac/256). Otherwise base is the unchanged membrane.
- R6: `fire_out` rises one cycle after the cycle in which the membrane is strictly greater than the signed `threshold` while no refractory window is open.
- R7: After `fire_out` is high, it stays low for at least REF_LEN (8) further cycles. It fires again as soon as the window closes if the membrane still exceeds the threshold.
- R8: A spike arriving while a synapse waveform is active restarts that waveform at the start of its delay.
- R9: Firing does not change the membrane; the accumulator keeps integrating across and after a spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spike_in | input | 16 | One spike bit per synapse |
| cfg_delay | input | 128 | Per-synapse silent wait in cycles, 8 bits each |
| cfg_rise_exp | input | 48 | Per-synapse rise length exponent, 3 bits each |
| cfg_hold | input | 128 | Per-synapse plateau length in cycles, 8 bits each |
| cfg_fall_exp | input | 48 | Per-synapse fall length exponent, 3 bits each |
| cfg_height | input | 128 | Per-synapse signed peak current, 8 bits each |
| decay_frac | input | 8 | Leak multiplier in 1/256 units |
| decay_exp | input | 4 | Leak interval is 2^decay_exp cycles |
| threshold | input | 24 | Signed firing threshold |
| fire_out | output | 1 | Output spike, one cycle wide |
| membrane | output | 24 | Signed membrane potential |

## Verification
A spike sampled at edge e changes the synapse state at e. Its first non-zero current is therefore added at edge e+td+1 and shows on `membrane` just after that edge. `fire_out` reflects the membrane of the cycle before it. The bench keeps a behavioural model that advances at each rising edge from the same inputs the design sees. It compares `membrane` and `fire_out` at the following falling edge, so every result is checked in exactly the cycle it is due. Separate named checks cover the reset value, the gap between output spikes and the membrane surviving a spike.

// File: rtl/tlif_pkg.sv
// Shared types for the temporal leaky-integrate-and-fire neuron.
package tlif_pkg;
    // Phase of one synapse's trapezoidal current pulse.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DELAY = 3'd1,
        PH_RISE  = 3'd2,
        PH_HOLD  = 3'd3,
        PH_FALL  = 3'd4
    } psr_phase_e;
endpackage

// File: rtl/tlif_psr_gen.sv
// One synapse current generator. A sampled spike starts (or restarts)
// a trapezoid: td zero cycles, 2^rs rising samples, tp plateau cycles,
// 2^fs falling samples. Assumes 2^(2^SW-1) fits in TW bits.
module tlif_psr_gen
    import tlif_pkg::*;
#(
    parameter int TW = 8,
    parameter int SW = 3,
    parameter int HW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spike,
    input  logic [TW-1:0]        td,
    input  logic [SW-1:0]        rise_sh,
    input  logic [TW-1:0]        tp,
    input  logic [SW-1:0]        fall_sh,
    input  logic signed [HW-1:0] height,
    output logic signed [HW-1:0] cur
);
    localparam int PW = HW + TW + 2;

    psr_phase_e      phase, phase_nx;
    logic [TW-1:0]   cnt, cnt_nx;
    logic [TW-1:0]   rise_last, fall_last;
    logic [TW:0]     ramp_k;
    logic [SW-1:0]   ramp_sh;
    logic signed [PW-1:0] prod, shifted;

    // Last counter value of each ramp phase.
    always_comb begin
        rise_last = TW'((1 << rise_sh) - 1);
        fall_last = TW'((1 << fall_sh) - 1);
    end

    // Phase sequencing; a spike always wins and restarts the pulse.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt + 1'b1;
        if (spike) begin
            phase_nx = (td != '0) ? PH_DELAY : PH_RISE;
            cnt_nx   = '0;
        end else begin
            unique case (phase)
                PH_IDLE:  cnt_nx = '0;
                PH_DELAY: if (cnt == td - 1'b1) begin
                              phase_nx = PH_RISE;
                              cnt_nx   = '0;
                          end
                PH_RISE:  if (cnt == rise_last) begin
                              phase_nx = (tp != '0) ? PH_HOLD : PH_FALL;
                              cnt_nx   = '0;
                          end
                PH_HOLD:  if (cnt == tp - 1'b1) begin
                              phase_nx = PH_FALL;
                              cnt_nx   = '0;
                          end
                PH_FALL:  if (cnt == fall_last) begin
                              phase_nx = PH_IDLE;
                              cnt_nx   = '0;
                          end
                default:  begin
                              phase_nx = PH_IDLE;
                              cnt_nx   = '0;
                          end
            endcase
        end
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // Ramp multiplier operands for the rising or falling edge.
    always_comb begin
        if (phase == PH_FALL) begin
            ramp_k  = {1'b0, fall_last} - {1'b0, cnt};
            ramp_sh = fall_sh;
        end else begin
            ramp_k  = {1'b0, cnt} + 1'b1;
            ramp_sh = rise_sh;
        end
        prod    = PW'(height) * $signed({1'b0, ramp_k});
        shifted = prod >>> ramp_sh;
    end

    // Current sample for the present phase.
    always_comb begin
        unique case (phase)
            PH_RISE, PH_FALL: cur = shifted[HW-1:0];
            PH_HOLD:          cur = height;
            default:          cur = '0;
        endcase
    end

    // R8: a spike restarts the pulse at its first cycle.
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spike |=> (cnt == '0) && (phase == PH_DELAY || phase == PH_RISE));

    // R2: a quiet generator produces no current.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !spike) |=> (cur == '0));
endmodule

// File: rtl/tlif_accum.sv
// Membrane accumulator: adds the summed synapse currents every cycle and,
// every 2^decay_exp cycles, first scales the stored value by frac/256.
// Saturates to the signed AW-bit range.
module tlif_accum #(
    parameter int N  = 16,
    parameter int HW = 8,
    parameter int AW = 24,
    parameter int FW = 8,
    parameter int KW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N*HW-1:0]      cur_flat,
    input  logic [FW-1:0]        decay_frac,
    input  logic [KW-1:0]        decay_exp,
    output logic signed [AW-1:0] acc
);
    localparam int CW   = 1 << KW;
    localparam int SUMW = HW + $clog2(N) + 1;
    localparam int EXTW = AW + 2;
    localparam int MW   = AW + FW + 1;
    localparam logic signed [EXTW-1:0] SAT_HI = {{(EXTW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [EXTW-1:0] SAT_LO = ~SAT_HI;

    logic [CW-1:0]          tcnt, tmask;
    logic                   tick;
    logic signed [SUMW-1:0] sum;
    logic signed [MW-1:0]   scaled;
    logic signed [AW-1:0]   base;
    logic signed [EXTW-1:0] total;

    // Free-running interval counter and decay tick.
    always_comb begin
        tmask = CW'((1 << decay_exp) - 1);
        tick  = (tcnt & tmask) == tmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tcnt <= '0;
        else        tcnt <= tcnt + 1'b1;
    end

    // Sum of all synapse currents this cycle.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++)
            sum = sum + SUMW'($signed(cur_flat[i*HW +: HW]));
    end

    // Leak step followed by integration and saturation.
    always_comb begin
        scaled = (MW'(acc) * $signed({1'b0, decay_frac})) >>> FW;
        base   = tick ? scaled[AW-1:0] : acc;
        total  = EXTW'(base) + EXTW'(sum);
    end

    // Membrane register.
    always_ff @(posedge clk) begin
        if (!rst_n)             acc <= '0;
        else if (total > SAT_HI) acc <= SAT_HI[AW-1:0];
        else if (total < SAT_LO) acc <= SAT_LO[AW-1:0];
        else                    acc <= total[AW-1:0];
    end

    // R5: a leak step with no input never grows a positive membrane.
    assert_leak_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sum == '0 && acc >= 0) |=> (acc <= $past(acc)));

    // R4: with no input and no tick the membrane holds.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && sum == '0) |=> $stable(acc));
endmodule

// File: rtl/tlif_refractory.sv
// Threshold comparator gated by a refractory shift register.
// A fire pushes a one in; while any stage holds a one, firing is masked.
module tlif_refractory #(
    parameter int AW = 24,
    parameter int RL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] membrane,
    input  logic signed [AW-1:0] threshold,
    output logic                 fire
);
    logic [RL-1:0] hold_sr;
    logic          blocked, fire_d;

    // Comparator with refractory mask.
    always_comb begin
        blocked = |hold_sr;
        fire_d  = (membrane > threshold) && !blocked;
    end

    // Output spike and refractory shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire    <= 1'b0;
            hold_sr <= '0;
        end else begin
            fire    <= fire_d;
            hold_sr <= {hold_sr[RL-2:0], fire_d};
        end
    end

    // R7: two output spikes are never adjacent.
    assert_refr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/tlif_neuron.sv
// Top of the temporal leaky-integrate-and-fire neuron: per-synapse
// trapezoidal current generators, a leaky saturating accumulator and a
// refractory-gated threshold. Per-synapse fields are packed at i*width.
module tlif_neuron #(
    parameter int N_SYN   = 16,
    parameter int TW      = 8,
    parameter int SW      = 3,
    parameter int HW      = 8,
    parameter int AW      = 24,
    parameter int FW      = 8,
    parameter int KW      = 4,
    parameter int REF_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SYN-1:0]    spike_in,
    input  logic [N_SYN*TW-1:0] cfg_delay,
    input  logic [N_SYN*SW-1:0] cfg_rise_exp,
    input  logic [N_SYN*TW-1:0] cfg_hold,
    input  logic [N_SYN*SW-1:0] cfg_fall_exp,
    input  logic [N_SYN*HW-1:0] cfg_height,
    input  logic [FW-1:0]       decay_frac,
    input  logic [KW-1:0]       decay_exp,
    input  logic [AW-1:0]       threshold,
    output logic                fire_out,
    output logic [AW-1:0]       membrane
);
    logic [N_SYN*HW-1:0] cur_flat;
    logic signed [AW-1:0] acc;

    // One current generator per synapse.
    for (genvar g = 0; g < N_SYN; g++) begin : g_syn
        logic signed [HW-1:0] cur_g;
        tlif_psr_gen #(.TW(TW), .SW(SW), .HW(HW)) u_psr (
            .clk     (clk),
            .rst_n   (rst_n),
            .spike   (spike_in[g]),
            .td      (cfg_delay[g*TW +: TW]),
            .rise_sh (cfg_rise_exp[g*SW +: SW]),
            .tp      (cfg_hold[g*TW +: TW]),
            .fall_sh (cfg_fall_exp[g*SW +: SW]),
            .height  ($signed(cfg_height[g*HW +: HW])),
            .cur     (cur_g)
        );
        assign cur_flat[g*HW +: HW] = cur_g;
    end

    tlif_accum #(.N(N_SYN), .HW(HW), .AW(AW), .FW(FW), .KW(KW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_flat   (cur_flat),
        .decay_frac (decay_frac),
        .decay_exp  (decay_exp),
        .acc        (acc)
    );

    tlif_refractory #(.AW(AW), .RL(REF_LEN)) u_refr (
        .clk       (clk),
        .rst_n     (rst_n),
        .membrane  (acc),
        .threshold ($signed(threshold)),
        .fire      (fire_out)
    );

    assign membrane = acc;

    // R6: an output spike follows a membrane above threshold.
    assert_fire_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_out |-> ($signed($past(membrane)) > $signed($past(threshold))));
endmodule

// File: tb/tlif_neuron_test.sv
// Bench: behavioural model advanced at each rising edge, compared at the
// following falling edge.
module tlif_neuron_test;
    localparam int N  = 16;
    localparam int RL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   spike_in = '0;
    logic [N*8-1:0] cfg_delay = '0, cfg_hold = '0, cfg_height = '0;
    logic [N*3-1:0] cfg_rise_exp = '0, cfg_fall_exp = '0;
    logic [7:0]     decay_frac = 8'd255;
    logic [3:0]     decay_exp = 4'd15;
    logic [23:0]    threshold = 24'h7FFFFF;
    logic           fire_out;
    logic [23:0]    membrane;

    always #2 clk = ~clk;

    tlif_neuron uut (
        .clk(clk), .rst_n(rst_n), .spike_in(spike_in),
        .cfg_delay(cfg_delay), .cfg_rise_exp(cfg_rise_exp), .cfg_hold(cfg_hold),
        .cfg_fall_exp(cfg_fall_exp), .cfg_height(cfg_height),
        .decay_frac(decay_frac), .decay_exp(decay_exp), .threshold(threshold),
        .fire_out(fire_out), .membrane(membrane)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    string tag = "R1";

    // Model state.
    int  m_ph [N];
    int  m_cn [N];
    longint m_acc = 0;
    int  m_tcnt = 0;
    int  m_rc = 0;
    bit  m_fire = 0;
    int  cyc = 0, last_fire = -1000;

    function automatic int syn_cur(int i);
        int h, rs, fs;
        h  = int'($signed(cfg_height[i*8 +: 8]));
        rs = int'(cfg_rise_exp[i*3 +: 3]);
        fs = int'(cfg_fall_exp[i*3 +: 3]);
        case (m_ph[i])
            2: return (h * (m_cn[i] + 1)) >>> rs;
            3: return h;
            4: return (h * ((1 << fs) - 1 - m_cn[i])) >>> fs;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        longint sum, base, tot;
        int mask;
        if (!rst_n) begin
            foreach (m_ph[i]) begin m_ph[i] = 0; m_cn[i] = 0; end
            m_acc = 0; m_tcnt = 0; m_rc = 0; m_fire = 0;
            return;
        end
        sum = 0;
        for (int i = 0; i < N; i++) sum += syn_cur(i);
        mask = (1 << decay_exp) - 1;
        base = ((m_tcnt & mask) == mask) ? ((m_acc * longint'(decay_frac)) >>> 8) : m_acc;
        m_fire = (m_acc > longint'($signed(threshold))) && (m_rc == 0);
        m_rc = m_fire ? RL : ((m_rc > 0) ? m_rc - 1 : 0);
        tot = base + sum;
        if (tot > 8388607) tot = 8388607;
        if (tot < -8388608) tot = -8388608;
        m_acc = tot;
        m_tcnt = (m_tcnt + 1) & 16'hFFFF;
        for (int i = 0; i < N; i++) begin
            int td, tp, rl, fl;
            td = int'(cfg_delay[i*8 +: 8]);
            tp = int'(cfg_hold[i*8 +: 8]);
            rl = (1 << cfg_rise_exp[i*3 +: 3]) - 1;
            fl = (1 << cfg_fall_exp[i*3 +: 3]) - 1;
            if (spike_in[i]) begin
                m_ph[i] = (td > 0) ? 1 : 2; m_cn[i] = 0;
            end else case (m_ph[i])
                1: if (m_cn[i] == td - 1) begin m_ph[i] = 2; m_cn[i] = 0; end else m_cn[i]++;
                2: if (m_cn[i] == rl) begin m_ph[i] = (tp > 0) ? 3 : 4; m_cn[i] = 0; end else m_cn[i]++;
                3: if (m_cn[i] == tp - 1) begin m_ph[i] = 4; m_cn[i] = 0; end else m_cn[i]++;
                4: if (m_cn[i] == fl) begin m_ph[i] = 0; m_cn[i] = 0; end else m_cn[i]++;
                default: ;
            endcase
        end
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // One clock: model at the rising edge, comparison at the falling edge.
    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            cyc++;
            check(longint'($signed(membrane)) == m_acc, tag, "membrane",
                  longint'($signed(membrane)), m_acc);
            check(fire_out == m_fire, tag, "fire_out", fire_out, m_fire);
            if (fire_out && rst_n) begin
                check(cyc - last_fire >= RL + 1, "R7", "fire gap", cyc - last_fire, RL + 1);
                last_fire = cyc;
            end
        end
    endtask

    task automatic set_syn(int i, int td, int rs, int tp, int fs, int h);
        cfg_delay[i*8 +: 8]    = 8'(td);
        cfg_rise_exp[i*3 +: 3] = 3'(rs);
        cfg_hold[i*8 +: 8]     = 8'(tp);
        cfg_fall_exp[i*3 +: 3] = 3'(fs);
        cfg_height[i*8 +: 8]   = 8'(h);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            finish_run();
        end
    end

    initial begin
        int fires;
        // R1: reset state
        tag = "R1";
        step(3);
        check(membrane == 0, "R1", "reset membrane", membrane, 0);
        check(fire_out == 0, "R1", "reset fire", fire_out, 0);
        rst_n = 1'b1;

        // R2: single excitatory pulse with delay, plateau, fall
        tag = "R2";
        set_syn(0, 3, 2, 2, 1, 20);
        step(2);
        spike_in[0] = 1'b1; step(1); spike_in[0] = 1'b0;
        step(20);
        // R2: zero delay and zero plateau are skipped
        set_syn(0, 0, 0, 0, 2, 33);
        spike_in[0] = 1'b1; step(1); spike_in[0] = 1'b0;
        step(10);

        // R3: inhibitory synapse alongside an excitatory one
        tag = "R3";
        set_syn(1, 1, 3, 4, 3, -15);
        set_syn(0, 2, 1, 3, 2, 9);
        spike_in[1:0] = 2'b11; step(1); spike_in = '0;
        step(30);
        check(longint'($signed(membrane)) < 1000, "R3", "inhibition lowered", longint'($signed(membrane)), 1000);

        // R8: retrigger during the rise and during the plateau
        tag = "R8";
        set_syn(2, 2, 3, 5, 2, 40);
        spike_in[2] = 1'b1; step(1); spike_in[2] = 1'b0;
        step(5);
        spike_in[2] = 1'b1; step(1); spike_in[2] = 1'b0;
        step(14);
        spike_in[2] = 1'b1; step(1); spike_in[2] = 1'b0;
        step(25);

        // R4: positive then negative saturation with all synapses
        tag = "R4";
        for (int i = 0; i < N; i++) set_syn(i, 0, 0, 255, 0, 127);
        for (int r = 0; r < 50; r++) begin
            spike_in = '1; step(1); spike_in = '0; step(99);
        end
        check(longint'($signed(membrane)) == 8388607, "R4", "positive saturation",
              longint'($signed(membrane)), 8388607);
        for (int i = 0; i < N; i++) set_syn(i, 0, 0, 255, 0, -128);
        for (int r = 0; r < 90; r++) begin
            spike_in = '1; step(1); spike_in = '0; step(99);
        end
        check(longint'($signed(membrane)) == -8388608, "R4", "negative saturation",
              longint'($signed(membrane)), -8388608);
        step(300);

        // R5: leak only, two intervals
        tag = "R5";
        decay_frac = 8'd200; decay_exp = 4'd3;
        step(120);
        decay_frac = 8'd128; decay_exp = 4'd0;
        step(40);

        // R6, R7, R9: sustained drive with leak and threshold
        tag = "R1";
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        for (int i = 0; i < N; i++) set_syn(i, 0, 0, 0, 0, 0);
        tag = "R6";
        set_syn(0, 0, 0, 255, 0, 50);
        decay_frac = 8'd240; decay_exp = 4'd2;
        threshold = 24'd3000;
        fires = 0;
        for (int r = 0; r < 20; r++) begin
            spike_in[0] = 1'b1; step(1); spike_in[0] = 1'b0;
            for (int k = 0; k < 99; k++) begin
                step(1);
                if (fire_out) begin
                    fires++;
                    check(membrane != 0, "R9", "membrane kept after fire",
                          longint'($signed(membrane)), m_acc);
                end
            end
        end
        check(fires > 10, "R7", "repeat firing", fires, 11);
        // R6: threshold equal to a held membrane does not fire
        tag = "R6";
        set_syn(0, 0, 0, 0, 0, 0);
        decay_exp = 4'd15; decay_frac = 8'd255;
        step(4);
        threshold = membrane;
        step(30);
        check(fire_out == 0, "R6", "equal is not above", fire_out, 0);

        finished = 1;
        finish_run();
    end
endmodule